// File: doc/BRIEF.md
# In-Order Retirement Window with Speculation Squash and Precise Faults

This block keeps the program order of instructions that are in flight in an out-of-order core. The issue logic claims one slot per instruction at the tail of a circular window and receives a tag for it. Execution units report finished work against that tag in any order and may attach a fault. The window hands instructions back in their original order, one per cycle, from the oldest slot.

An instruction issued beyond an unresolved branch is marked speculative and cannot leave the window until the branch is settled. A correctly predicted branch releases those slots. A wrong prediction marks them dead, and the window then drains them from the oldest end at one slot per cycle, with no retire pulse for any of them. A fault is stored in its slot and has no effect until that slot is the oldest live one. At that point the window raises a one-cycle flush, reports the faulting tag, and empties itself. Every older instruction has already retired, and no younger one ever will.

Top module: `rob_window`

## Requirements
- R1: After reset the window is empty: `full`, `retire_valid` and `flush` are low, and `alloc_tag` is 0.
- R2: Each accepted allocation (`alloc_ok` high, which needs `alloc_req` high and `full` low) receives `alloc_tag` equal to the previous tag plus one, modulo DEPTH.
- R3: After DEPTH allocations with no slot freed, `full` is high. A further request is refused (`alloc_ok` low) and `alloc_tag` does not move.
- R4: Retirement happens only from the oldest slot, at most once per cycle. Tags retire in allocation order whatever the order of completion.
- R5: While the oldest slot has not completed, `retire_valid` stays low, even if younger slots have completed.
- R6: A completed slot marked speculative is not retired until a branch resolve arrives with `br_miss` = 0. That resolve clears the mark on every speculative slot.
- R7: A resolve with `br_miss` = 1 kills every speculative slot, whether or not it has completed. Killed slots are freed one per cycle from the oldest end. No `retire_valid` and no `flush` is produced for them, even when they recorded a fault, and tag numbering continues without a break.
- R8: A fault reported through `cmpl_exc` = 1 has no visible effect while any older slot is still live.
- R9: When the oldest live slot has completed with a fault, `flush` is high for one cycle with `flush_tag` equal to its tag, and `retire_valid` is low. All younger slots are removed, and the next allocation receives tag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_req | input | 1 | Request a new slot at the tail |
| alloc_spec | input | 1 | New instruction lies beyond an unresolved branch |
| alloc_ok | output | 1 | Request accepted this cycle |
| alloc_tag | output | TAG_W | Tag given to the accepted request |
| full | output | 1 | No free slot |
| cmpl_valid | input | 1 | An execution unit finished an instruction |
| cmpl_tag | input | TAG_W | Tag of the finished instruction |
| cmpl_exc | input | 1 | The finished instruction faulted |
| br_valid | input | 1 | The pending branch resolved this cycle |
| br_miss | input | 1 | 1: prediction was wrong, kill speculative slots; 0: confirm them |
| retire_valid | output | 1 | Oldest slot commits this cycle |
| retire_tag | output | TAG_W | Tag of the committing slot |
| flush | output | 1 | Oldest slot faulted; window is emptied |
| flush_tag | output | TAG_W | Tag of the faulting slot |

## Verification
The bench completes tags in reverse and scrambled order. A design that retired on completion, and not from the oldest slot, would produce tags out of sequence. It fills the window past its pointer wrap to find a full flag taken from the index bits alone, since such a flag would accept an allocation over a live slot. It gives a killed speculative slot a fault, which exposes a design that flushes on dead work or emits a retire pulse for it. It also reports a fault on a younger slot before the oldest one completes, which catches a design that acts on faults early or lets instructions behind the fault escape.

// File: rtl/rob_pkg.sv
package rob_pkg;

   // State held for one in-flight instruction.
   typedef struct packed {
      logic valid;   // slot occupied
      logic done;    // execution finished
      logic exc;     // fault recorded at completion
      logic spec;    // beyond an unresolved branch
      logic kill;    // on a squashed path, to be drained
   } rob_slot_t;

endpackage

// File: rtl/rob_ptr.sv
module rob_ptr #(
   parameter int DEPTH = 8,
   localparam int TAG_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [TAG_W:0]   ptr
);

   // One extra bit above the index toggles on each wrap.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr <= '0;
      else if (clr)
         ptr <= '0;
      else if (inc)
         ptr <= ptr + 1'b1;
   end

endmodule

// File: rtl/rob_slot.sv
module rob_slot
   import rob_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      clr,
   input  logic      alloc_hit,
   input  logic      alloc_spec,
   input  logic      cmpl_hit,
   input  logic      cmpl_exc,
   input  logic      br_valid,
   input  logic      br_miss,
   input  logic      free_hit,
   output rob_slot_t st
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= '0;
      end else if (clr) begin
         st <= '0;
      end else if (alloc_hit) begin
         st       <= '0;
         st.valid <= 1'b1;
         st.spec  <= alloc_spec;
      end else if (free_hit) begin
         st <= '0;
      end else if (st.valid) begin
         if (cmpl_hit) begin
            st.done <= 1'b1;
            st.exc  <= cmpl_exc;
         end
         if (br_valid && st.spec) begin
            st.spec <= 1'b0;
            st.kill <= br_miss;
         end
      end
   end

endmodule

// File: rtl/rob_head_ctl.sv
module rob_head_ctl
   import rob_pkg::*;
(
   input  rob_slot_t hs,
   input  logic      occupied,
   output logic      commit,
   output logic      drop,
   output logic      fault
);

   logic live;
   logic ready;

   always_comb begin
      live   = occupied & hs.valid;
      drop   = live & hs.kill;
      ready  = live & ~hs.kill & ~hs.spec & hs.done;
      commit = ready & ~hs.exc;
      fault  = ready & hs.exc;
   end

endmodule

// File: rtl/rob_window.sv
module rob_window
   import rob_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int TAG_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_req,
   input  logic             alloc_spec,
   output logic             alloc_ok,
   output logic [TAG_W-1:0] alloc_tag,
   output logic             full,
   input  logic             cmpl_valid,
   input  logic [TAG_W-1:0] cmpl_tag,
   input  logic             cmpl_exc,
   input  logic             br_valid,
   input  logic             br_miss,
   output logic             retire_valid,
   output logic [TAG_W-1:0] retire_tag,
   output logic             flush,
   output logic [TAG_W-1:0] flush_tag
);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_depth_chk
         $error("rob_window: DEPTH must be a power of two and at least 2");
      end
   endgenerate

   logic [TAG_W:0]   hd_q;
   logic [TAG_W:0]   tl_q;
   logic [TAG_W-1:0] hd_idx;
   logic [TAG_W-1:0] tl_idx;
   logic             is_empty;
   logic             is_full;
   logic             commit;
   logic             drop;
   logic             fault;
   logic             advance;
   rob_slot_t        slot_st [DEPTH];
   rob_slot_t        head_st;

   always_comb begin
      hd_idx   = hd_q[TAG_W-1:0];
      tl_idx   = tl_q[TAG_W-1:0];
      is_empty = (hd_q == tl_q);
      is_full  = (hd_q[TAG_W] != tl_q[TAG_W]) && (hd_idx == tl_idx);
      head_st  = slot_st[hd_idx];
      advance  = commit | drop;
      alloc_ok = alloc_req & ~is_full & ~fault;
   end

   rob_head_ctl u_hctl (
      .hs       (head_st),
      .occupied (~is_empty),
      .commit   (commit),
      .drop     (drop),
      .fault    (fault)
   );

   rob_ptr #(.DEPTH(DEPTH)) u_tail (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (fault),
      .inc   (alloc_ok),
      .ptr   (tl_q)
   );

   rob_ptr #(.DEPTH(DEPTH)) u_head (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (fault),
      .inc   (advance),
      .ptr   (hd_q)
   );

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         rob_slot u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr        (fault),
            .alloc_hit  (alloc_ok && (tl_idx == TAG_W'(i))),
            .alloc_spec (alloc_spec),
            .cmpl_hit   (cmpl_valid && (cmpl_tag == TAG_W'(i))),
            .cmpl_exc   (cmpl_exc),
            .br_valid   (br_valid),
            .br_miss    (br_miss),
            .free_hit   (advance && (hd_idx == TAG_W'(i))),
            .st         (slot_st[i])
         );
      end
   endgenerate

   assign alloc_tag    = tl_idx;
   assign full         = is_full;
   assign retire_valid = commit;
   assign retire_tag   = hd_idx;
   assign flush        = fault;
   assign flush_tag    = hd_idx;

endmodule

// File: rtl/rob_window_chk.sv
module rob_window_chk #(
   parameter int DEPTH = 8,
   localparam int TAG_W = $clog2(DEPTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             alloc_ok,
   input logic [TAG_W-1:0] alloc_tag,
   input logic             full,
   input logic             retire_valid,
   input logic [TAG_W-1:0] retire_tag,
   input logic             flush
);

   // R2
   tag_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_ok |=> (alloc_tag == TAG_W'($past(alloc_tag) + 1'b1)));

   // R3
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !flush) |=> $stable(alloc_tag));

   // R4
   retire_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      retire_valid |=> (retire_tag == TAG_W'($past(retire_tag) + 1'b1)));

   // R9
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!full && !retire_valid && alloc_tag == '0));

   // R9
   flush_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(flush && retire_valid));

endmodule

bind rob_window rob_window_chk #(.DEPTH(DEPTH)) i_rob_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .alloc_ok     (alloc_ok),
   .alloc_tag    (alloc_tag),
   .full         (full),
   .retire_valid (retire_valid),
   .retire_tag   (retire_tag),
   .flush        (flush)
);

// File: tb/test_rob_window.sv
module test_rob_window;

   localparam int DEPTH = 8;
   localparam int TAG_W = $clog2(DEPTH);

   logic             clk = 0;
   logic             rst_n = 0;
   logic             alloc_req = 0;
   logic             alloc_spec = 0;
   logic             alloc_ok;
   logic [TAG_W-1:0] alloc_tag;
   logic             full;
   logic             cmpl_valid = 0;
   logic [TAG_W-1:0] cmpl_tag = '0;
   logic             cmpl_exc = 0;
   logic             br_valid = 0;
   logic             br_miss = 0;
   logic             retire_valid;
   logic [TAG_W-1:0] retire_tag;
   logic             flush;
   logic [TAG_W-1:0] flush_tag;

   rob_window #(.DEPTH(DEPTH)) i_rob_window (
      .clk(clk), .rst_n(rst_n),
      .alloc_req(alloc_req), .alloc_spec(alloc_spec),
      .alloc_ok(alloc_ok), .alloc_tag(alloc_tag), .full(full),
      .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag), .cmpl_exc(cmpl_exc),
      .br_valid(br_valid), .br_miss(br_miss),
      .retire_valid(retire_valid), .retire_tag(retire_tag),
      .flush(flush), .flush_tag(flush_tag)
   );

   always #5 clk = ~clk;

   typedef struct {
      int tag;
      bit spec;
      bit kill;
      bit exc;
   } item_t;

   item_t mq[$];
   int    n_cmp = 0;
   int    n_bad = 0;
   int    exp_tail = 0;
   int    flush_seen = 0;
   bit    finished = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Monitor: pops the expected program order as the design retires or flushes.
   always @(negedge clk) begin
      if (rst_n && (retire_valid || flush)) begin
         while (mq.size() > 0 && mq[0].kill) void'(mq.pop_front());
         if (mq.size() == 0) begin
            chk(0, retire_valid ? "R7 retire of removed slot" : "R7 unexpected flush",
                retire_valid ? int'(retire_tag) : int'(flush_tag), -1);
         end else if (retire_valid) begin
            chk(int'(retire_tag) == mq[0].tag, "R4 retire order", int'(retire_tag), mq[0].tag);
            chk(!mq[0].spec, "R6 speculative slot retired", 1, 0);
            chk(!mq[0].exc, "R9 faulting slot retired", 1, 0);
            void'(mq.pop_front());
         end else begin
            chk(int'(flush_tag) == mq[0].tag && mq[0].exc, "R9 flush tag",
                int'(flush_tag), mq[0].tag);
            flush_seen++;
            mq.delete();
            exp_tail = 0;
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic alloc(input bit spec, input bit expect_ok, input string req);
      item_t it;
      alloc_req  = 1;
      alloc_spec = spec;
      #1;
      chk(alloc_ok == expect_ok, {req, " alloc_ok"}, int'(alloc_ok), int'(expect_ok));
      if (alloc_ok) begin
         chk(int'(alloc_tag) == exp_tail, {req, " alloc_tag"}, int'(alloc_tag), exp_tail);
         it.tag = int'(alloc_tag); it.spec = spec; it.kill = 0; it.exc = 0;
         mq.push_back(it);
         exp_tail = (exp_tail + 1) % DEPTH;
      end
      @(negedge clk);
      alloc_req  = 0;
      alloc_spec = 0;
   endtask

   task automatic complete(input int tag, input bit exc);
      cmpl_valid = 1;
      cmpl_tag   = TAG_W'(tag);
      cmpl_exc   = exc;
      foreach (mq[k]) if (mq[k].tag == tag) mq[k].exc = exc;
      @(negedge clk);
      cmpl_valid = 0;
      cmpl_exc   = 0;
   endtask

   task automatic resolve(input bit miss);
      br_valid = 1;
      br_miss  = miss;
      foreach (mq[k]) if (mq[k].spec) begin
         mq[k].spec = 0;
         mq[k].kill = miss;
      end
      @(negedge clk);
      br_valid = 0;
      br_miss  = 0;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         n_cmp++;
         $display("FAIL watchdog: actual 1 expected 0");
         summary();
         $finish;
      end
   end

   initial begin
      int base;
      idle(2);
      rst_n = 1;
      idle(1);
      // R1: reset state
      chk(!full && !retire_valid && !flush && alloc_tag == 0, "R1 reset state",
          {full, retire_valid, flush}, 0);

      // R2, R4, R5: in-order retire of out-of-order completions
      for (int i = 0; i < 4; i++) alloc(0, 1, "R2");
      complete(3, 0);
      complete(1, 0);
      complete(2, 0);
      #1 chk(!retire_valid, "R5 head incomplete", int'(retire_valid), 0);
      idle(1);
      chk(!retire_valid, "R5 head incomplete", int'(retire_valid), 0);
      complete(0, 0);
      idle(6);
      chk(mq.size() == 0, "R4 all retired", mq.size(), 0);

      // R3: fill across the pointer wrap
      base = exp_tail;
      for (int i = 0; i < DEPTH; i++) alloc(0, 1, "R3");
      chk(full, "R3 full flag", int'(full), 1);
      alloc(0, 0, "R3 refused");
      chk(int'(alloc_tag) == base, "R3 tail held", int'(alloc_tag), base);
      for (int i = DEPTH - 1; i >= 0; i--) complete((base + i) % DEPTH, 0);
      idle(DEPTH + 3);
      chk(mq.size() == 0 && !full, "R3 drained", mq.size(), 0);

      // R6: speculative slots wait for a confirming resolve
      base = exp_tail;
      alloc(0, 1, "R6");
      alloc(1, 1, "R6");
      alloc(1, 1, "R6");
      for (int i = 0; i < 3; i++) complete((base + i) % DEPTH, 0);
      idle(2);
      for (int i = 0; i < 3; i++) begin
         chk(!retire_valid, "R6 held while speculative", int'(retire_valid), 0);
         idle(1);
      end
      chk(mq.size() == 2, "R6 two still held", mq.size(), 2);
      resolve(0);
      idle(4);
      chk(mq.size() == 0, "R6 released", mq.size(), 0);

      // R7: mispredict drains killed slots silently, even a faulted one
      base = exp_tail;
      alloc(0, 1, "R7");
      alloc(1, 1, "R7");
      alloc(1, 1, "R7");
      complete(base, 0);
      complete((base + 1) % DEPTH, 1);
      resolve(1);
      idle(6);
      chk(flush_seen == 0, "R7 no flush for killed fault", flush_seen, 0);
      base = exp_tail;
      alloc(0, 1, "R7 numbering continues");
      complete(base, 0);
      idle(3);
      chk(mq.size() == 0 || (mq.size() > 0 && mq[0].kill), "R7 later slot retired",
          mq.size(), 0);
      while (mq.size() > 0 && mq[0].kill) void'(mq.pop_front());

      // R8, R9: fault held until oldest, then flush
      base = exp_tail;
      alloc(0, 1, "R8");
      alloc(0, 1, "R8");
      alloc(0, 1, "R8");
      complete((base + 1) % DEPTH, 1);
      idle(2);
      chk(!flush && !retire_valid, "R8 fault not yet acted on", int'(flush), 0);
      chk(flush_seen == 0, "R8 no early flush", flush_seen, 0);
      complete((base + 2) % DEPTH, 0);
      complete(base, 0);
      idle(4);
      chk(flush_seen == 1, "R9 flush raised once", flush_seen, 1);
      chk(!full, "R9 window empty", int'(full), 0);
      alloc(0, 1, "R9 tag restarts");
      complete(0, 0);
      idle(3);
      chk(mq.size() == 0, "R9 post-flush retire", mq.size(), 0);

      finished = 1;
      summary();
      $finish;
   end

endmodule